// File: doc/BRIEF.md
# DMA Request Remap and Interrupt Router

This block sits between a set of peripheral DMA request lines and an eight-channel DMA controller. Each DMA channel has a 6-bit selector that picks one of 43 peripheral request inputs and drives it onto that channel's request output. A selector value outside the peripheral range marks the channel as unmapped, and the channel's request is then held low. A second register steers each channel's completion interrupt to any subset of three CPU interrupt outputs. Each CPU also has its own enable bit that gates its output.

Software programs the block through a 32-bit register port in APB style. Two remap registers each hold four channel selectors, one per byte lane. Bit 31 of a remap write is a commit flag. A write that carries the flag loads the written selectors into the active routing in the same clock edge. A write without the flag only changes a staged copy, and reads return that staged copy. A parameter chooses whether the request and interrupt outputs pass through one output register stage.

Top module: `dmx_router`

## Requirements
- R1: After reset, every channel selector (staged and active) is 0x3F and the interrupt routing register is 0. Both remap registers read 0x3F3F3F3F, and all channel request and CPU interrupt outputs are low.
- R2: Channel n's selector is in the remap register at offset 0x154 + 4*(n/4), bits 8*(n%4)+5 down to 8*(n%4).
- R3: A write to a remap register with bit 31 set loads all four written selectors into the active routing at that clock edge.
- R4: A write to a remap register with bit 31 clear updates only the staged selectors, and the routing does not change. Reads return the staged selectors. Bit 31 and bits 7:6 of every byte read as 0, and those bits of a write never affect a selector.
- R5: A channel whose active selector s is in 0..42 drives its request output from peripheral request input s.
- R6: A channel whose active selector is in 43..63 (0x3F included) holds its request output low.
- R7: In the interrupt routing register at offset 0x298, bit cpu*10+ch set routes channel ch's completion interrupt to CPU cpu (cpu 0..2, ch 0..7).
- R8: CPU cpu's interrupt output is the OR of its routed channel interrupts, ANDed with the enable bit cpu*10+8.
- R9: Accesses to offsets other than 0x154, 0x158 and 0x298 complete without error. Reads there return 0, and writes there change nothing. Routing register bits that have no meaning (9, 19, 29, 30, 31) read as 0.
- R10: With the output register enabled (OUT_REG=1, the default), request and interrupt outputs change exactly one clock edge after their inputs or the routing change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| periph_req | input | N_PERIPH (43) | Peripheral DMA request lines |
| ch_done_irq | input | N_CH (8) | Per-channel completion interrupts from the DMA controller |
| chan_req | output | N_CH (8) | Per-channel DMA request outputs |
| cpu_irq | output | N_CPU (3) | Per-CPU interrupt outputs |

## Verification
The request multiplexer is exercised with a walking one across all 43 peripheral inputs, so that a selector pointing at the wrong input, or a byte lane wired to the wrong channel, is caught. It is also exercised with all-ones and alternating patterns, which separate unmapped channels (always low) from mapped ones. Selectors 43, 62 and 63 are applied under an all-ones input to show that only in-range values pass a request. The commit path is checked by staging a write without bit 31 and confirming that the routing stays the same while the readback changes, and then committing. The interrupt router is driven with one channel interrupt at a time, to tell each route bit apart, and with all interrupts at once while a CPU is disabled, to separate route bits from the enable gate.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int unsigned REMAP_BASE = 32'h154;
  localparam int unsigned INTR_OFF   = 32'h298;
  localparam int unsigned COMMIT_BIT = 31;
  localparam int unsigned CPU_SLICE  = 10;
  localparam int unsigned EN_POS     = 8;

  // Bits of the interrupt routing register that hold state.
  function automatic logic [31:0] intr_mask_f(input int n_cpu, input int n_ch);
    logic [31:0] m;
    m = '0;
    for (int c = 0; c < n_cpu; c++) begin
      for (int b = 0; b < n_ch; b++) m[c*CPU_SLICE + b] = 1'b1;
      m[c*CPU_SLICE + EN_POS] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
  import dmx_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int N_CPU  = 3,
  parameter int SEL_W  = 6,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic [N_CH*SEL_W-1:0]   sel_act,
  output logic [N_CPU*N_CH-1:0]   route,
  output logic [N_CPU-1:0]        cpu_en
);
  localparam int N_REMAP = N_CH / 4;
  localparam logic [31:0] INTR_MASK = intr_mask_f(N_CPU, N_CH);
  localparam logic [ADDR_W-1:0] INTR_ADDR = ADDR_W'(INTR_OFF);

  function automatic logic [ADDR_W-1:0] remap_addr(input int k);
    return ADDR_W'(REMAP_BASE + 4 * k);
  endfunction

  logic              wr;
  logic [SEL_W-1:0]  stg_q [N_CH];
  logic [SEL_W-1:0]  act_q [N_CH];
  logic [31:0]       intr_q;
  logic              hit_any;

  assign wr = psel & penable & pwrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < N_CH; n++) begin
        stg_q[n] <= '1;
        act_q[n] <= '1;
      end
      intr_q <= '0;
    end else if (wr) begin
      for (int n = 0; n < N_CH; n++) begin
        if (paddr == remap_addr(n / 4)) begin
          stg_q[n] <= pwdata[8*(n%4) +: SEL_W];
          if (pwdata[COMMIT_BIT]) act_q[n] <= pwdata[8*(n%4) +: SEL_W];
        end
      end
      if (paddr == INTR_ADDR) intr_q <= pwdata & INTR_MASK;
    end
  end

  always_comb begin
    for (int n = 0; n < N_CH; n++) sel_act[n*SEL_W +: SEL_W] = act_q[n];
    for (int c = 0; c < N_CPU; c++) begin
      for (int ch = 0; ch < N_CH; ch++) route[c*N_CH + ch] = intr_q[c*CPU_SLICE + ch];
      cpu_en[c] = intr_q[c*CPU_SLICE + EN_POS];
    end
  end

  always_comb begin
    prdata  = '0;
    hit_any = 1'b0;
    for (int k = 0; k < N_REMAP; k++)
      if (paddr == remap_addr(k)) hit_any = 1'b1;
    if (paddr == INTR_ADDR) begin
      hit_any = 1'b1;
      prdata  = intr_q;
    end
    for (int n = 0; n < N_CH; n++)
      if (paddr == remap_addr(n / 4)) prdata[8*(n%4) +: SEL_W] = stg_q[n];
  end

  // R9: undefined offsets read as zero
  a_r9_undef_read_zero: assert property (@(posedge clk) disable iff (rst)
    (psel && !hit_any) |-> (prdata == '0));
  // R4: commit flag never reads back
  a_r4_flag_reads_zero: assert property (@(posedge clk) disable iff (rst)
    psel |-> !prdata[COMMIT_BIT]);

  for (genvar n = 0; n < N_CH; n++) begin : g_chk
    // R3: committed write lands in the active selector at the next edge
    a_r3_commit_loads: assert property (@(posedge clk) disable iff (rst)
      (wr && pwdata[COMMIT_BIT] && paddr == remap_addr(n / 4))
      |=> (act_q[n] == $past(pwdata[8*(n%4) +: SEL_W])));
    // R4: a write without the flag leaves the active routing alone
    a_r4_stage_only: assert property (@(posedge clk) disable iff (rst)
      (wr && !pwdata[COMMIT_BIT]) |=> $stable(act_q[n]));
    // R1: first cycle out of reset sees every channel unmapped
    a_r1_reset_unmapped: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (act_q[n] == '1));
  end
endmodule

// File: rtl/dmx_req_mux.sv
module dmx_req_mux #(
  parameter int N_CH     = 8,
  parameter int N_PERIPH = 43,
  parameter int SEL_W    = 6
) (
  input  logic [N_PERIPH-1:0]     periph_req,
  input  logic [N_CH*SEL_W-1:0]   sel_act,
  output logic [N_CH-1:0]         req_raw
);
  localparam int N_SLOT = 2 ** SEL_W;

  // Slots at and above N_PERIPH are tied low, so out-of-range selectors
  // (the all-ones code included) produce an idle request.
  logic [N_SLOT-1:0] slots;
  assign slots = {{(N_SLOT - N_PERIPH){1'b0}}, periph_req};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign req_raw[ch] = slots[sel_act[ch*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/dmx_irq_route.sv
module dmx_irq_route #(
  parameter int N_CH  = 8,
  parameter int N_CPU = 3
) (
  input  logic [N_CH-1:0]        ch_done_irq,
  input  logic [N_CPU*N_CH-1:0]  route,
  input  logic [N_CPU-1:0]       cpu_en,
  output logic [N_CPU-1:0]       irq_raw
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    assign irq_raw[c] = cpu_en[c] & |(route[c*N_CH +: N_CH] & ch_done_irq);
  end
endmodule

// File: rtl/dmx_router.sv
module dmx_router #(
  parameter int N_CH     = 8,
  parameter int N_PERIPH = 43,
  parameter int N_CPU    = 3,
  parameter int SEL_W    = 6,
  parameter int ADDR_W   = 12,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic [N_PERIPH-1:0]  periph_req,
  input  logic [N_CH-1:0]      ch_done_irq,
  output logic [N_CH-1:0]      chan_req,
  output logic [N_CPU-1:0]     cpu_irq
);
  logic [N_CH*SEL_W-1:0]  sel_act;
  logic [N_CPU*N_CH-1:0]  route;
  logic [N_CPU-1:0]       cpu_en;
  logic [N_CH-1:0]        req_raw;
  logic [N_CPU-1:0]       irq_raw;

  dmx_regs #(.N_CH(N_CH), .N_CPU(N_CPU), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .sel_act(sel_act), .route(route), .cpu_en(cpu_en)
  );

  dmx_req_mux #(.N_CH(N_CH), .N_PERIPH(N_PERIPH), .SEL_W(SEL_W)) u_mux (
    .periph_req(periph_req), .sel_act(sel_act), .req_raw(req_raw)
  );

  dmx_irq_route #(.N_CH(N_CH), .N_CPU(N_CPU)) u_irq (
    .ch_done_irq(ch_done_irq), .route(route), .cpu_en(cpu_en), .irq_raw(irq_raw)
  );

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (rst) begin
        chan_req <= '0;
        cpu_irq  <= '0;
      end else begin
        chan_req <= req_raw;
        cpu_irq  <= irq_raw;
      end
    end
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_a_ch
      // R6: an out-of-range selector idles the channel one edge later
      a_r6_unmapped_low: assert property (@(posedge clk) disable iff (rst)
        (int'(sel_act[ch*SEL_W +: SEL_W]) >= N_PERIPH) |=> !chan_req[ch]);
    end
    for (genvar c = 0; c < N_CPU; c++) begin : g_a_cpu
      // R8: a disabled CPU sees no interrupt
      a_r8_cpu_gate: assert property (@(posedge clk) disable iff (rst)
        !cpu_en[c] |=> !cpu_irq[c]);
    end
  end else begin : g_comb
    assign chan_req = req_raw;
    assign cpu_irq  = irq_raw;
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_a_ch
      // R6: an out-of-range selector idles the channel
      a_r6_unmapped_low: assert property (@(posedge clk) disable iff (rst)
        (int'(sel_act[ch*SEL_W +: SEL_W]) >= N_PERIPH) |-> !chan_req[ch]);
    end
    for (genvar c = 0; c < N_CPU; c++) begin : g_a_cpu
      // R8: a disabled CPU sees no interrupt
      a_r8_cpu_gate: assert property (@(posedge clk) disable iff (rst)
        !cpu_en[c] |-> !cpu_irq[c]);
    end
  end
endmodule

// File: tb/dmx_router_tb.sv
module dmx_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [42:0] periph_req = '0;
  logic [7:0]  ch_done_irq = '0;
  logic [7:0]  chan_req;
  logic [2:0]  cpu_irq;

  int n_chk = 0;
  int n_bad = 0;

  // bench model, built from the requirements
  logic [5:0]  m_act [8];
  logic [5:0]  m_stg [8];
  logic [31:0] m_intr;

  always #4 clk = ~clk;

  dmx_router u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .periph_req(periph_req), .ch_done_irq(ch_done_irq),
    .chan_req(chan_req), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] intr_mask();
    logic [31:0] m = '0;
    for (int c = 0; c < 3; c++) m[c*10 +: 9] = 9'h1FF;
    return m;
  endfunction

  function automatic logic [7:0] exp_req(input logic [42:0] p);
    logic [7:0] r;
    for (int ch = 0; ch < 8; ch++) r[ch] = (m_act[ch] < 6'd43) ? p[m_act[ch]] : 1'b0;
    return r;
  endfunction

  function automatic logic [2:0] exp_irq(input logic [7:0] i);
    logic [2:0] r;
    for (int c = 0; c < 3; c++) r[c] = m_intr[c*10 + 8] & |(m_intr[c*10 +: 8] & i);
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] d = '0;
    if (a == 12'h154 || a == 12'h158)
      for (int b = 0; b < 4; b++) d[8*b +: 6] = m_stg[(a == 12'h158 ? 4 : 0) + b];
    else if (a == 12'h298) d = m_intr;
    return d;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    if (a == 12'h154 || a == 12'h158)
      for (int b = 0; b < 4; b++) begin
        m_stg[(a == 12'h158 ? 4 : 0) + b] = d[8*b +: 6];
        if (d[31]) m_act[(a == 12'h158 ? 4 : 0) + b] = d[8*b +: 6];
      end
    else if (a == 12'h298) m_intr = d & intr_mask();
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 chk(tag, 64'(prdata), 64'(exp_rd(a)));
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // drive peripheral lines and compare after one clock edge
  task automatic req_chk(input string tag, input logic [42:0] p);
    @(negedge clk);
    periph_req = p;
    @(negedge clk);
    chk(tag, 64'(chan_req), 64'(exp_req(p)));
  endtask

  task automatic irq_chk(input string tag, input logic [7:0] i);
    @(negedge clk);
    ch_done_irq = i;
    @(negedge clk);
    chk(tag, 64'(cpu_irq), 64'(exp_irq(i)));
  endtask

  task automatic t_reset();
    for (int n = 0; n < 8; n++) begin m_act[n] = 6'h3F; m_stg[n] = 6'h3F; end
    m_intr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_chk("R1 reset remap0", 12'h154);
    rd_chk("R1 reset remap1", 12'h158);
    rd_chk("R1 reset intr", 12'h298);
    chk("R1 reset readback literal", 64'(exp_rd(12'h154)), 64'h3F3F3F3F);
    ch_done_irq = 8'hFF;
    req_chk("R1 reset requests idle", {43{1'b1}});
    chk("R1 reset irqs idle", 64'(cpu_irq), 64'h0);
    ch_done_irq = 8'h00;
  endtask

  task automatic t_map();
    wr(12'h154, 32'hBF002A05);
    wr(12'h158, 32'hAD1E140A);
    rd_chk("R2 remap0 layout", 12'h154);
    rd_chk("R2 remap1 layout", 12'h158);
    for (int s = 0; s < 43; s++) req_chk($sformatf("R5 walk periph %0d", s), 43'(1) << s);
    req_chk("R5 all ones", {43{1'b1}});
    req_chk("R5 alternating", {22{2'b01}});
    req_chk("R5 alternating inv", {22{2'b10}});
  endtask

  task automatic t_stage();
    wr(12'h154, 32'h01020304);
    rd_chk("R4 staged readback", 12'h154);
    req_chk("R4 routing unchanged p5", 43'(1) << 5);
    req_chk("R4 routing unchanged p4", 43'(1) << 4);
    wr(12'h154, 32'h81020304);
    req_chk("R3 commit p4 to ch0", 43'(1) << 4);
    req_chk("R3 commit p1 to ch3", 43'(1) << 1);
    wr(12'h158, 32'hC5C5C5C5);
    rd_chk("R4 reserved bits read zero", 12'h158);
    req_chk("R4 reserved bits ignored", 43'(1) << 5);
  endtask

  task automatic t_unmapped();
    wr(12'h154, 32'hBF3E2B3F);
    wr(12'h158, 32'h8000002D);
    req_chk("R6 out-of-range selectors low", {43{1'b1}});
    chk("R6 ch0..3 and ch4 idle", 64'(chan_req & 8'h1F), 64'h0);
  endtask

  task automatic t_irq();
    wr(12'h298, 32'h82842301);
    rd_chk("R9 undefined routing bits zero", 12'h298);
    for (int ch = 0; ch < 8; ch++) irq_chk($sformatf("R7 single irq ch%0d", ch), 8'(1) << ch);
    irq_chk("R8 all irqs cpu2 disabled", 8'hFF);
    chk("R8 cpu2 gated", 64'(cpu_irq[2]), 64'h0);
    wr(12'h298, 32'h12842101);
    irq_chk("R8 cpu2 enabled ch5", 8'h20);
    irq_chk("R8 cpu2 enabled ch3", 8'h08);
    irq_chk("R8 OR of routes", 8'h29);
  endtask

  task automatic t_undef();
    wr(12'h154, 32'h83020100);
    rd_chk("R9 undefined read zero", 12'h100);
    rd_chk("R9 undefined read zero 2", 12'h29C);
    wr(12'h100, 32'hFFFFFFFF);
    wr(12'h15C, 32'hFFFFFFFF);
    rd_chk("R9 remap0 untouched", 12'h154);
    rd_chk("R9 intr untouched", 12'h298);
    req_chk("R9 routing untouched", 43'(1) << 2);
  endtask

  task automatic t_latency();
    wr(12'h154, 32'h80000007);
    @(negedge clk);
    periph_req = '0;
    @(negedge clk);
    periph_req = 43'(1) << 7;
    #1 chk("R10 no same-cycle change", 64'(chan_req[0]), 64'h0);
    @(negedge clk);
    chk("R10 change after one edge", 64'(chan_req[0]), 64'h1);
  endtask

  initial begin
    t_reset();
    t_map();
    t_stage();
    t_unmapped();
    t_irq();
    t_undef();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule